// File: doc/BRIEF.md
# TLB Refill Page Walker

This block services a miss in the translation buffer without software help. Given the virtual address that missed, it forms the address of the page table entry inside a virtually mapped page-table window, asks the translation buffer to translate that address as a privileged load, reads the 32-bit entry from memory and writes a new translation into one of the four refillable small-page ways. On success it also loads the faulting-address register with the missing address.

The walk never nests. If the window address itself misses or is refused, or if the memory read reports a bus error, the walk ends and the requester gets back the miss cause it supplied. The victim way comes from a small round-robin counter that advances before it is used and only on a successful refill. One walk runs at a time. A new miss is accepted only while `walk_ready` is high.

Top module: `pte_refill_walker`

## Requirements
- R1: After reset `walk_ready` is 1 and `lk_req`, `rd_req_valid`, `tlb_we`, `fault_addr_we` and `done_valid` are all 0.
- R2: For an accepted miss at address V with base B, `lk_req` is high for exactly one cycle with `lk_vaddr` = (B | (V >> 10)) with bits 1:0 cleared.
- R3: If that lookup misses (`lk_hit`=0) or faults (`lk_fault`=1), the walk ends with `done_ok`=0 and `done_cause` equal to the cause captured with the miss, and no memory read and no entry write take place.
- R4: On a clean lookup, `rd_req_addr` equals `lk_paddr`, and `rd_req_valid` stays high with a stable address until `rd_req_ready` is seen.
- R5: A read response with `rd_rsp_err`=1 ends the walk with `done_ok`=0, the captured miss cause, and no entry write and no faulting-address write.
- R6: A written entry has `tlb_ppn` = entry data with bits 11:0 cleared and `tlb_attr` = entry bits 3:0.
- R7: `tlb_asid` is byte R of `asid_bytes` (bits 8R+7:8R), where R is entry bits 5:4.
- R8: The refill way is the round-robin counter plus one, modulo four. The counter is 0 after reset, so the first refill goes to way 1, then 2, 3, 0. Failed walks do not move it.
- R9: `tlb_vpn` is the missing address with bits 11:0 cleared, and `tlb_index` is its bits starting at bit 12 (bits 13:12 by default).
- R10: `fault_addr_we` pulses in the same cycle as `tlb_we` with `fault_addr` equal to the missing address, and never on a failed walk.
- R11: While a walk is in progress `walk_ready` is 0 and `miss_valid` is ignored. Every walk yields exactly one `done_valid` pulse, based on the accepted address.
- R12: `done_valid` is a one-cycle pulse. On success it follows the write cycle directly, with `done_ok`=1 and `done_cause`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss to be serviced |
| miss_vaddr | input | 32 | Virtual address that missed |
| miss_cause | input | CAUSE_W | Cause to return if the walk fails |
| walk_ready | output | 1 | Walker idle, miss accepted |
| pt_base | input | 32 | Page-table window base |
| asid_bytes | input | 32 | Four ASID bytes, one per ring |
| lk_req | output | 1 | Lookup of the entry address (ring-0 load) |
| lk_vaddr | output | 32 | Entry virtual address |
| lk_hit | input | 1 | Lookup hit |
| lk_fault | input | 1 | Lookup refused |
| lk_paddr | input | 32 | Translated entry address |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Request accepted |
| rd_req_addr | output | 32 | Physical read address |
| rd_rsp_valid | input | 1 | Read response |
| rd_rsp_data | input | 32 | Page table entry |
| rd_rsp_err | input | 1 | Bus error on read |
| tlb_we | output | 1 | Write refilled entry |
| tlb_way | output | WAY_W | Victim way |
| tlb_index | output | IDX_W | Entry index in way |
| tlb_vpn | output | 32 | Virtual page |
| tlb_ppn | output | 32 | Physical page |
| tlb_asid | output | 8 | ASID of new entry |
| tlb_attr | output | 4 | Attribute of new entry |
| fault_addr_we | output | 1 | Write faulting-address register |
| fault_addr | output | 32 | Faulting address value |
| done_valid | output | 1 | Walk finished |
| done_ok | output | 1 | Walk succeeded |
| done_cause | output | CAUSE_W | Returned cause (0 on success) |

## Verification
The hardest situation to reach from the ports is a miss arriving while a walk is still in flight, with a read slave that stalls. The miss must be dropped while the request is held stable across the stall. The stimulus raises `miss_valid` with a different address during the lookup and request cycles, and withholds `rd_req_ready` at random. It then confirms that only the first address shows up in the entry and the faulting-address register. The round-robin order is reached by mixing failed and successful walks, which shows that failures leave the victim sequence unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PTE_SHIFT  = 10;
  localparam int ASID_W     = 8;
  localparam int ATTR_W     = 4;
  localparam int RING_LSB   = 4;

  typedef enum logic [2:0] {
    PW_IDLE   = 3'd0,
    PW_XLATE  = 3'd1,
    PW_RDREQ  = 3'd2,
    PW_RDWAIT = 3'd3,
    PW_WRITE  = 3'd4,
    PW_DONE   = 3'd5
  } pw_state_t;
endpackage

// File: rtl/ptw_pte_addr.sv
module ptw_pte_addr
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] pte_va
);
  always_comb begin
    pte_va = base | (vaddr >> PTE_SHIFT);
    pte_va[1:0] = 2'b00;
  end
endmodule

// File: rtl/ptw_victim_ctr.sv
module ptw_victim_ctr #(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WAY_W-1:0] way_next
);
  logic [WAY_W-1:0] cnt_q;

  assign way_next = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= way_next;
  end
endmodule

// File: rtl/ptw_entry_fmt.sv
module ptw_entry_fmt
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] pte,
  input  logic [31:0]       asid_bytes,
  output logic [ADDR_W-1:0] ppn,
  output logic [ATTR_W-1:0] attr,
  output logic [ASID_W-1:0] asid
);
  logic [1:0] ring;

  always_comb begin
    ring = pte[RING_LSB +: 2];
    attr = pte[ATTR_W-1:0];
    ppn  = pte;
    ppn[PAGE_SHIFT-1:0] = '0;
    asid = asid_bytes[ring*ASID_W +: ASID_W];
  end
endmodule

// File: rtl/pte_refill_walker.sv
module pte_refill_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter int CAUSE_W = 6,
  parameter int WAY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [31:0]        miss_vaddr,
  input  logic [CAUSE_W-1:0] miss_cause,
  output logic               walk_ready,
  input  logic [31:0]        pt_base,
  input  logic [31:0]        asid_bytes,
  output logic               lk_req,
  output logic [31:0]        lk_vaddr,
  input  logic               lk_hit,
  input  logic               lk_fault,
  input  logic [31:0]        lk_paddr,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [31:0]        rd_req_addr,
  input  logic               rd_rsp_valid,
  input  logic [31:0]        rd_rsp_data,
  input  logic               rd_rsp_err,
  output logic               tlb_we,
  output logic [WAY_W-1:0]   tlb_way,
  output logic [IDX_W-1:0]   tlb_index,
  output logic [31:0]        tlb_vpn,
  output logic [31:0]        tlb_ppn,
  output logic [7:0]         tlb_asid,
  output logic [3:0]         tlb_attr,
  output logic               fault_addr_we,
  output logic [31:0]        fault_addr,
  output logic               done_valid,
  output logic               done_ok,
  output logic [CAUSE_W-1:0] done_cause
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  pw_state_t          state_q, state_d;
  logic [ADDR_W-1:0]  va_q, ptva_q, rdaddr_q, pte_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               ok_q;
  logic [ADDR_W-1:0]  ptva_d;

  logic en_miss, en_lk, en_pte, en_write;
  logic lk_clean;

  assign lk_clean = lk_hit && !lk_fault;
  assign en_miss  = (state_q == PW_IDLE)   && miss_valid;
  assign en_lk    = (state_q == PW_XLATE)  && lk_clean;
  assign en_pte   = (state_q == PW_RDWAIT) && rd_rsp_valid && !rd_rsp_err;
  assign en_write = (state_q == PW_WRITE);

  ptw_pte_addr u_addr (
    .base   (pt_base),
    .vaddr  (miss_vaddr),
    .pte_va (ptva_d)
  );

  ptw_victim_ctr #(.WAY_W(WAY_W)) u_victim (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .adv      (en_write),
    .way_next (tlb_way)
  );

  ptw_entry_fmt u_fmt (
    .pte        (pte_q),
    .asid_bytes (asid_bytes),
    .ppn        (tlb_ppn),
    .attr       (tlb_attr),
    .asid       (tlb_asid)
  );

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PW_IDLE:   if (miss_valid) state_d = PW_XLATE;
      PW_XLATE:  state_d = lk_clean ? PW_RDREQ : PW_DONE;
      PW_RDREQ:  if (rd_req_ready) state_d = PW_RDWAIT;
      PW_RDWAIT: if (rd_rsp_valid) state_d = rd_rsp_err ? PW_DONE : PW_WRITE;
      PW_WRITE:  state_d = PW_DONE;
      PW_DONE:   state_d = PW_IDLE;
      default:   state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) state_q <= PW_IDLE;
    else          state_q <= state_d;
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      va_q     <= '0;
      ptva_q   <= '0;
      cause_q  <= '0;
      rdaddr_q <= '0;
      pte_q    <= '0;
      ok_q     <= 1'b0;
    end else begin
      if (en_miss) begin
        va_q    <= miss_vaddr;
        ptva_q  <= ptva_d;
        cause_q <= miss_cause;
        ok_q    <= 1'b0;
      end
      if (en_lk)    rdaddr_q <= lk_paddr;
      if (en_pte)   pte_q    <= rd_rsp_data;
      if (en_write) ok_q     <= 1'b1;
    end
  end

  assign walk_ready    = (state_q == PW_IDLE);
  assign lk_req        = (state_q == PW_XLATE);
  assign lk_vaddr      = ptva_q;
  assign rd_req_valid  = (state_q == PW_RDREQ);
  assign rd_req_addr   = rdaddr_q;
  assign tlb_we        = en_write;
  assign tlb_index     = va_q[PAGE_SHIFT +: IDX_W];
  assign tlb_vpn       = {va_q[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign fault_addr_we = en_write;
  assign fault_addr    = va_q;
  assign done_valid    = (state_q == PW_DONE);
  assign done_ok       = ok_q;
  assign done_cause    = ok_q ? '0 : cause_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int IDX_W   = 2,
  parameter int CAUSE_W = 6,
  parameter int WAY_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             walk_ready,
  input logic             lk_req,
  input logic [31:0]      lk_vaddr,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [31:0]      rd_req_addr,
  input logic             tlb_we,
  input logic [WAY_W-1:0] tlb_way,
  input logic [31:0]      tlb_vpn,
  input logic             fault_addr_we,
  input logic [31:0]      fault_addr,
  input logic             done_valid,
  input logic             done_ok
);
  logic [WAY_W-1:0] last_way_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_way_q <= '0;
      seen_q     <= 1'b0;
    end else if (tlb_we) begin
      last_way_q <= tlb_way;
      seen_q     <= 1'b1;
    end
  end

  assert_pte_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> lk_vaddr[1:0] == 2'b00);

  assert_lookup_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !(lk_hit && !lk_fault) |=> done_valid && !done_ok && !rd_req_valid);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_way_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we && seen_q |-> tlb_way == WAY_W'(last_way_q + 1'b1));

  assert_fault_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |-> fault_addr_we && fault_addr[31:12] == tlb_vpn[31:12]);

  assert_fault_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_addr_we |-> tlb_we);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_ready && miss_valid |=> lk_req && !walk_ready);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && walk_ready);

  assert_write_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |=> done_valid && done_ok);
endmodule

bind pte_refill_walker ptw_checker #(
  .IDX_W(IDX_W), .CAUSE_W(CAUSE_W), .WAY_W(WAY_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .walk_ready    (walk_ready),
  .lk_req        (lk_req),
  .lk_vaddr      (lk_vaddr),
  .lk_hit        (lk_hit),
  .lk_fault      (lk_fault),
  .rd_req_valid  (rd_req_valid),
  .rd_req_ready  (rd_req_ready),
  .rd_req_addr   (rd_req_addr),
  .tlb_we        (tlb_we),
  .tlb_way       (tlb_way),
  .tlb_vpn       (tlb_vpn),
  .fault_addr_we (fault_addr_we),
  .fault_addr    (fault_addr),
  .done_valid    (done_valid),
  .done_ok       (done_ok)
);

// File: tb/pte_refill_walker_bench.sv
module pte_refill_walker_bench;
  localparam int IDX_W   = 2;
  localparam int CAUSE_W = 6;
  localparam int WAY_W   = 2;
  localparam logic [31:0] PXOR = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst_n;
  logic miss_valid;
  logic [31:0] miss_vaddr;
  logic [CAUSE_W-1:0] miss_cause;
  logic walk_ready;
  logic [31:0] pt_base, asid_bytes;
  logic lk_req;
  logic [31:0] lk_vaddr;
  logic lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic rd_req_valid, rd_req_ready;
  logic [31:0] rd_req_addr;
  logic rd_rsp_valid;
  logic [31:0] rd_rsp_data;
  logic rd_rsp_err;
  logic tlb_we;
  logic [WAY_W-1:0] tlb_way;
  logic [IDX_W-1:0] tlb_index;
  logic [31:0] tlb_vpn, tlb_ppn;
  logic [7:0] tlb_asid;
  logic [3:0] tlb_attr;
  logic fault_addr_we;
  logic [31:0] fault_addr;
  logic done_valid, done_ok;
  logic [CAUSE_W-1:0] done_cause;

  int checks = 0;
  int fails  = 0;
  int rr_model = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign lk_paddr = lk_vaddr ^ PXOR;

  pte_refill_walker #(.IDX_W(IDX_W), .CAUSE_W(CAUSE_W), .WAY_W(WAY_W)) u_pte_refill_walker (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_cause(miss_cause),
    .walk_ready(walk_ready), .pt_base(pt_base), .asid_bytes(asid_bytes),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_paddr(lk_paddr), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_err(rd_rsp_err), .tlb_we(tlb_we), .tlb_way(tlb_way), .tlb_index(tlb_index),
    .tlb_vpn(tlb_vpn), .tlb_ppn(tlb_ppn), .tlb_asid(tlb_asid), .tlb_attr(tlb_attr),
    .fault_addr_we(fault_addr_we), .fault_addr(fault_addr),
    .done_valid(done_valid), .done_ok(done_ok), .done_cause(done_cause)
  );

  task automatic chk(input bit c, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ptva(input logic [31:0] b, input logic [31:0] v);
    logic [31:0] r;
    r = b | (v >> 10);
    r[1:0] = 2'b00;
    return r;
  endfunction

  // lkmode: 0 lookup miss, 1 lookup fault, 2 clean hit
  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic [CAUSE_W-1:0] cause,
                      input int lkmode, input logic [31:0] pte, input bit err, input bit inject);
    int lk_cnt = 0, rd_cnt = 0, we_cnt = 0, fa_cnt = 0, done_cnt = 0;
    bit rd_moved = 0, hs_pend = 0, done_after_we = 0, we_prev = 0, rdy_seen = 0;
    int wait_n = 0, post = 0;
    logic [31:0] lk_va = 0, rd_a = 0, fa_v = 0, vpn_v = 0, ppn_v = 0;
    logic [7:0] asid_v = 0;
    logic [3:0] attr_v = 0;
    logic [WAY_W-1:0] way_v = 0;
    logic [IDX_W-1:0] idx_v = 0;
    bit ok_v = 0;
    logic [CAUSE_W-1:0] cause_v = 0;
    logic [31:0] e_ptva;
    logic [1:0] ring;
    bit good;

    @(negedge clk);
    pt_base = base; lk_hit = (lkmode != 0); lk_fault = (lkmode == 1);
    miss_vaddr = va; miss_cause = cause; miss_valid = 1'b1;
    for (int cyc = 1; cyc < 80; cyc++) begin
      @(negedge clk);
      rd_rsp_valid = 1'b0; rd_req_ready = 1'b0;
      if (inject && cyc <= 2) begin
        miss_valid = 1'b1; miss_vaddr = ~va; miss_cause = ~cause;
      end else begin
        miss_valid = 1'b0; miss_vaddr = va; miss_cause = cause;
      end
      if (lk_req) begin lk_cnt++; lk_va = lk_vaddr; end
      if (rd_req_valid) begin
        if (rd_cnt > 0 && rd_req_addr != rd_a) rd_moved = 1;
        rd_cnt++; rd_a = rd_req_addr;
        if (($urandom % 3) != 0) begin
          rd_req_ready = 1'b1; rdy_seen = 1; hs_pend = 1; wait_n = $urandom % 3;
        end
      end else if (hs_pend) begin
        if (wait_n == 0) begin
          rd_rsp_valid = 1'b1; rd_rsp_data = pte; rd_rsp_err = err; hs_pend = 0;
        end else begin
          rd_rsp_valid = 1'b0; rd_rsp_data = $urandom; rd_rsp_err = ~err; wait_n--;
        end
      end
      if (tlb_we) begin
        we_cnt++; way_v = tlb_way; idx_v = tlb_index; vpn_v = tlb_vpn;
        ppn_v = tlb_ppn; asid_v = tlb_asid; attr_v = tlb_attr;
      end
      if (fault_addr_we) begin fa_cnt++; fa_v = fault_addr; end
      if (done_valid) begin
        done_cnt++; ok_v = done_ok; cause_v = done_cause; done_after_we = we_prev;
      end
      we_prev = tlb_we;
      if (done_cnt > 0) begin
        post++;
        if (post > 3) break;
      end
    end
    miss_valid = 1'b0; rd_rsp_valid = 1'b0; rd_req_ready = 1'b0;

    e_ptva = exp_ptva(base, va);
    chk(lk_cnt == 1, "R2 lookup cycles", lk_cnt, 1);
    chk(lk_va == e_ptva, "R2 entry address", lk_va, e_ptva);
    chk(done_cnt == 1, "R11 one done per walk", done_cnt, 1);
    if (lkmode != 2) begin
      chk(rd_cnt == 0 && we_cnt == 0, "R3 no read or write", rd_cnt + we_cnt, 0);
      chk(ok_v == 0 && cause_v == cause, "R3 original cause", {ok_v, cause_v}, {1'b0, cause});
    end else begin
      chk(rd_a == (e_ptva ^ PXOR) && !rd_moved && rdy_seen, "R4 read address", rd_a, e_ptva ^ PXOR);
      if (err) begin
        chk(we_cnt == 0 && fa_cnt == 0, "R5 no write on bus error", we_cnt + fa_cnt, 0);
        chk(ok_v == 0 && cause_v == cause, "R5 original cause", {ok_v, cause_v}, {1'b0, cause});
        chk(fa_cnt == 0, "R10 no fault address on failure", fa_cnt, 0);
      end else begin
        ring = pte[5:4];
        good = (we_cnt == 1);
        chk(good, "R12 single write", we_cnt, 1);
        chk(ppn_v == {pte[31:12], 12'h000}, "R6 ppn", ppn_v, {pte[31:12], 12'h000});
        chk(attr_v == pte[3:0], "R6 attr", attr_v, pte[3:0]);
        chk(asid_v == asid_bytes[ring*8 +: 8], "R7 asid", asid_v, asid_bytes[ring*8 +: 8]);
        rr_model = (rr_model + 1) % 4;
        chk(way_v == WAY_W'(rr_model), "R8 victim way", way_v, rr_model);
        chk(vpn_v == {va[31:12], 12'h000}, "R9 vpn", vpn_v, {va[31:12], 12'h000});
        chk(idx_v == va[13:12], "R9 index", idx_v, va[13:12]);
        chk(fa_cnt == 1 && fa_v == va, "R10 fault address", fa_v, va);
        chk(ok_v == 1 && cause_v == 0 && done_after_we, "R12 success report",
            {ok_v, cause_v, done_after_we}, {1'b1, {CAUSE_W{1'b0}}, 1'b1});
      end
    end
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected below 150000", wd);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; miss_valid = 1'b0; miss_vaddr = '0; miss_cause = '0;
    pt_base = 32'h8000_0000; asid_bytes = 32'h0403_0201;
    lk_hit = 1'b0; lk_fault = 1'b0; rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0; rd_rsp_data = '0; rd_rsp_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(walk_ready && !lk_req && !rd_req_valid && !tlb_we && !fault_addr_we && !done_valid,
        "R1 reset state", {walk_ready, lk_req, rd_req_valid, tlb_we, fault_addr_we, done_valid},
        6'b100000);

    // directed: first refill goes to way 1 (R8)
    walk(32'h1234_5678, 32'h8000_0000, 6'd24, 2, 32'hABCD_E035, 0, 0);
    // lookup miss and lookup fault keep the counter (R3, R8)
    walk(32'h0000_3000, 32'hC000_0000, 6'd16, 0, 32'h0, 0, 0);
    walk(32'hFFFF_F000, 32'hC000_0000, 6'd17, 1, 32'h0, 0, 0);
    // bus error (R5)
    walk(32'h7654_3210, 32'h2000_0000, 6'd26, 2, 32'h1111_1111, 1, 0);
    // each ring selects its ASID byte (R7), busy miss ignored (R11)
    asid_bytes = 32'hA4B3_C2D1;
    for (int r = 0; r < 4; r++)
      walk(32'h0000_2000 + (r << 12), 32'h9000_0000, 6'd24, 2,
           32'h5555_5000 | (r << 4) | r, 0, (r == 2));
    // random mix
    for (int i = 0; i < 60; i++) begin
      int m;
      m = $urandom % 6;
      asid_bytes = $urandom;
      walk($urandom, $urandom, CAUSE_W'($urandom), (m == 0) ? 0 : (m == 1) ? 1 : 2,
           $urandom, ($urandom % 6) == 0, ($urandom % 4) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule